// File: doc/BRIEF.md
# Serial Fraction Adder with Sign-Driven Select

This unit adds or subtracts two 32-bit fractional words one binary digit per clock. It also offers a select operation that returns one of two operands, chosen by the sign of the most recent arithmetic result. Each word holds a kind tag in bit 31, where 1 marks an instruction word and 0 marks a number. Bit 30 is the sign, and bits 29:0 are the fraction. Bits 30:0 together form a two's complement value scaled by 2^-30, so every number lies in [-1, 1).

Operations enter through a valid/ready request port and leave through a valid/ready result port. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. While an operation runs, `in_ready` stays low. A finished result stays on `out_word` with `out_valid` high until an edge where `out_ready` is high. Until then the result does not change and no new request is taken, so a slow consumer throttles the producer. The low 31 bits pass through a carry flip-flop one bit per clock, least significant first. Subtraction inverts the second operand and presets the carry to one.

Top module: `sa_unit`

## Requirements
- R1: After reset, `in_ready` is 1, and `out_valid`, `sign_flag`, `ovf_flag` and `err_flag` are all 0.
- R2: Op code 2'b00 (add) returns bits 30:0 equal to (a[30:0] + b[30:0]) mod 2^31, with tag bit 31 = 0.
- R3: Op code 2'b01 (subtract) returns bits 30:0 equal to (a[30:0] - b[30:0]) mod 2^31, with tag bit 31 = 0.
- R4: For add or subtract, `out_ovf` is 1 exactly when the true signed result falls outside [-1, 1). `ovf_flag` becomes 1 on such a result and stays 1 until reset.
- R5: `out_valid` rises exactly 31 clock edges after the edge that accepted the request. `in_ready` and `out_valid` are never high together.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_word` and `out_ovf` hold their values.
- R7: `sign_flag` equals bit 30 of the most recent add or subtract result. It changes only on the edge where that result becomes valid.
- R8: Op codes 2'b10 and 2'b11 (select) return the whole of operand a when `sign_flag` is 0, and the whole of operand b when it is 1. The tag is included, `out_ovf` is 0, and `sign_flag` is unchanged.
- R9: An add or subtract request in which either operand has bit 31 set is consumed without producing a result. `err_flag` becomes 1 and stays 1 until reset, and `sign_flag` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle, request accepted this edge if valid |
| in_op | input | 2 | 00 add, 01 subtract, 1x select |
| in_a | input | 32 | First operand word |
| in_b | input | 32 | Second operand word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this edge |
| out_word | output | 32 | Result word |
| out_ovf | output | 1 | Overflow of this result |
| sign_flag | output | 1 | Held sign of last arithmetic result |
| ovf_flag | output | 1 | Sticky overflow |
| err_flag | output | 1 | Sticky instruction-word arithmetic error |

## Verification
The assertions assume that the consumer keeps `out_ready` at a known level and that requests change only between edges. They also assume that `in_a` and `in_b` are stable on the accepting edge, because the rejection check reads the tags there. The stimulus drives every input on the falling edge and releases `in_valid` right after acceptance. It applies random back-pressure lengths to each result. It generates numbers with tag 0 so that only the directed cases exercise rejection.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_SELA = 2'b10,
    OP_SELB = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } st_e;
endpackage

// File: rtl/sa_ctrl.sv
module sa_ctrl
  import sa_pkg::*;
#(
  parameter int NBITS = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic step,
  output logic last
);
  localparam int CW = $clog2(NBITS);

  st_e           st_q;
  logic [CW-1:0] cnt_q;

  assign in_ready  = (st_q == ST_IDLE);
  assign out_valid = (st_q == ST_DONE);
  assign step      = (st_q == ST_RUN);
  assign last      = step && (cnt_q == CW'(NBITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q  <= ST_RUN;
          cnt_q <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last) st_q <= ST_DONE;
        end
        ST_DONE: if (out_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sa_serial_add.sv
module sa_serial_add (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic cin_init,
  input  logic step,
  input  logic a_bit,
  input  logic b_bit,
  output logic sum_bit,
  output logic cin_bit,
  output logic cout_bit
);
  logic carry_q;

  assign cin_bit  = carry_q;
  assign sum_bit  = a_bit ^ b_bit ^ carry_q;
  assign cout_bit = (a_bit & b_bit) | (carry_q & (a_bit ^ b_bit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    carry_q <= 1'b0;
    else if (load) carry_q <= cin_init;
    else if (step) carry_q <= cout_bit;
  end
endmodule

// File: rtl/sa_shreg.sv
module sa_shreg #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] nxt;

  assign q = q_r;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == W - 1) begin : g_top
        assign nxt[i] = ser_in;
      end else begin : g_mid
        assign nxt[i] = q_r[i+1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_r <= '0;
    else if (load)  q_r <= load_val;
    else if (shift) q_r <= nxt;
  end
endmodule

// File: rtl/sa_unit.sv
module sa_unit
  import sa_pkg::*;
#(
  parameter int WORD_W = sa_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_ovf,
  output logic              sign_flag,
  output logic              ovf_flag,
  output logic              err_flag
);
  localparam int NBITS = WORD_W - 1;
  localparam int TAG   = WORD_W - 1;

  logic             is_arith, is_sub, bad, fire, start;
  logic             step, last;
  logic [WORD_W-1:0] chosen;
  logic [NBITS-1:0] a_load, b_load, a_q, b_q, r_q;
  logic             sum_bit, cin_bit, cout_bit, res_bit;
  logic             sel_q, tag_q, sign_q, ovf_last_q, ovf_q, err_q;

  assign is_arith = ~in_op[1];
  assign is_sub   = (in_op == OP_SUB);
  assign bad      = is_arith & (in_a[TAG] | in_b[TAG]);
  assign fire     = in_valid & in_ready;
  assign start    = fire & ~bad;
  assign chosen   = sign_q ? in_b : in_a;
  assign a_load   = is_arith ? in_a[NBITS-1:0] : chosen[NBITS-1:0];
  assign b_load   = is_sub ? ~in_b[NBITS-1:0] : in_b[NBITS-1:0];
  assign res_bit  = sel_q ? a_q[0] : sum_bit;

  sa_ctrl #(.NBITS(NBITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .step(step), .last(last)
  );

  sa_shreg #(.W(NBITS)) u_opa (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(a_load),
    .shift(step), .ser_in(1'b0), .q(a_q)
  );

  sa_shreg #(.W(NBITS)) u_opb (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(b_load),
    .shift(step), .ser_in(1'b0), .q(b_q)
  );

  sa_shreg #(.W(NBITS)) u_res (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val('0),
    .shift(step), .ser_in(res_bit), .q(r_q)
  );

  sa_serial_add u_add (
    .clk(clk), .rst_n(rst_n), .load(start), .cin_init(is_sub), .step(step),
    .a_bit(a_q[0]), .b_bit(b_q[0]),
    .sum_bit(sum_bit), .cin_bit(cin_bit), .cout_bit(cout_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= 1'b0;
      tag_q      <= 1'b0;
      sign_q     <= 1'b0;
      ovf_last_q <= 1'b0;
      ovf_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (fire && bad) err_q <= 1'b1;
      if (start) begin
        sel_q <= ~is_arith;
        tag_q <= is_arith ? 1'b0 : chosen[TAG];
      end
      if (last) begin
        if (sel_q) begin
          ovf_last_q <= 1'b0;
        end else begin
          sign_q     <= sum_bit;
          ovf_last_q <= cin_bit ^ cout_bit;
          if (cin_bit ^ cout_bit) ovf_q <= 1'b1;
        end
      end
    end
  end

  assign out_word  = {tag_q, r_q};
  assign out_ovf   = ovf_last_q;
  assign sign_flag = sign_q;
  assign ovf_flag  = ovf_q;
  assign err_flag  = err_q;
endmodule

// File: rtl/sa_checker.sv
module sa_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_op,
  input logic [WORD_W-1:0] in_a,
  input logic [WORD_W-1:0] in_b,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word,
  input logic              out_ovf,
  input logic              sign_flag,
  input logic              ovf_flag,
  input logic              err_flag
);
  localparam int NBITS = WORD_W - 1;
  localparam int LW    = $clog2(WORD_W) + 2;

  logic          act_q;
  logic [LW-1:0] lat_q;
  logic          take_ok;

  assign take_ok = in_valid && in_ready &&
                   !(!in_op[1] && (in_a[WORD_W-1] || in_b[WORD_W-1]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      lat_q <= '0;
    end else if (take_ok) begin
      act_q <= 1'b1;
      lat_q <= '0;
    end else if (act_q && !out_valid) begin
      lat_q <= lat_q + 1'b1;
    end else if (out_valid) begin
      act_q <= 1'b0;
    end
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_q == LW'(NBITS)));

  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_ovf));

  assert_sticky_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  assert_ovf_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ovf |-> ovf_flag);

  assert_sign_when_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sign_flag) |-> $rose(out_valid));

  assert_sticky_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_op[1] && (in_a[WORD_W-1] || in_b[WORD_W-1])
    |=> in_ready && err_flag && $stable(sign_flag));
endmodule

bind sa_unit sa_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
  .out_ready(out_ready), .out_word(out_word), .out_ovf(out_ovf),
  .sign_flag(sign_flag), .ovf_flag(ovf_flag), .err_flag(err_flag)
);

// File: tb/sim_sa_unit.sv
`timescale 1ns/1ps
module sim_sa_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'b00;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_word;
  logic        out_ovf, sign_flag, ovf_flag, err_flag;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic m_sign = 1'b0;
  logic m_ovf  = 1'b0;

  always #2.5 clk = ~clk;

  sa_unit u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [30:0] f_res(input logic [30:0] a, input logic [30:0] b, input bit sub);
    return sub ? (a - b) : (a + b);
  endfunction

  function automatic bit f_ovf(input logic [30:0] a, input logic [30:0] b, input bit sub);
    longint sa, sb, s;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    s  = sub ? sa - sb : sa + sb;
    return (s < -(64'sd1 <<< 30)) || (s > ((64'sd1 <<< 30) - 1));
  endfunction

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       input int bp, output logic [31:0] w, output logic ov, output int lat);
    logic [31:0] held;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(posedge clk); #1;
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 100) begin
      @(posedge clk); #1;
      lat++;
    end
    held = out_word;
    for (int i = 0; i < bp; i++) begin
      @(posedge clk); #1;
      chk(out_valid && out_word == held, "R6 hold", longint'(out_word), longint'(held));
    end
    w = out_word; ov = out_ovf;
    @(negedge clk); out_ready = 1'b1;
    @(posedge clk); #1; out_ready = 1'b0;
  endtask

  task automatic do_arith(input bit sub, input logic [31:0] a, input logic [31:0] b, input int bp);
    logic [31:0] w; logic ov; int lat;
    logic [30:0] er; bit eo;
    er = f_res(a[30:0], b[30:0], sub);
    eo = f_ovf(a[30:0], b[30:0], sub);
    issue(sub ? 2'b01 : 2'b00, a, b, bp, w, ov, lat);
    m_sign = er[30];
    m_ovf  = m_ovf | eo;
    chk(w == {1'b0, er}, sub ? "R3 diff" : "R2 sum", longint'(w), longint'({1'b0, er}));
    chk(ov == eo, "R4 out_ovf", longint'(ov), longint'(eo));
    chk(ovf_flag == m_ovf, "R4 sticky", longint'(ovf_flag), longint'(m_ovf));
    chk(lat == 31, "R5 latency", longint'(lat), 64'd31);
    chk(sign_flag == m_sign, "R7 sign", longint'(sign_flag), longint'(m_sign));
  endtask

  task automatic do_sel(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] w; logic ov; int lat; logic [31:0] ew;
    ew = m_sign ? b : a;
    issue(2'b10, a, b, 1, w, ov, lat);
    chk(w == ew, "R8 select", longint'(w), longint'(ew));
    chk(ov == 1'b0, "R8 ovf", longint'(ov), 64'd0);
    chk(sign_flag == m_sign, "R8 sign kept", longint'(sign_flag), longint'(m_sign));
  endtask

  task automatic do_reject(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    bit seen = 0;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(posedge clk); #1;
    in_valid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (out_valid) seen = 1;
    end
    chk(!seen, "R9 no result", longint'(seen), 64'd0);
    chk(err_flag == 1'b1, "R9 err", longint'(err_flag), 64'd1);
    chk(in_ready == 1'b1, "R9 ready", longint'(in_ready), 64'd1);
    chk(sign_flag == m_sign, "R9 sign kept", longint'(sign_flag), longint'(m_sign));
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      summary();
    end
  end

  initial begin
    logic [31:0] r1, r2;
    void'($urandom(32'd4711));
    #1;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 handshake", longint'({in_ready, out_valid}), 64'h2);
    chk({sign_flag, ovf_flag, err_flag} == 3'b000, "R1 flags",
        longint'({sign_flag, ovf_flag, err_flag}), 64'd0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    do_arith(0, 32'h1000_0000, 32'h0800_0000, 0);
    do_arith(0, 32'h3FFF_FFFF, 32'h0000_0000, 2);
    do_arith(0, 32'h6000_0000, 32'h6000_0000, 1);
    do_sel(32'h0000_0011, 32'h8000_0022);
    do_arith(1, 32'h0000_0000, 32'h0000_0001, 0);
    do_sel(32'h8000_0033, 32'h0000_0044);
    do_arith(1, 32'h0000_0001, 32'h0000_0001, 3);
    do_sel(32'h8000_0055, 32'h0000_0066);
    do_arith(0, 32'h2000_0000, 32'h2000_0000, 0);
    do_arith(1, 32'h4000_0000, 32'h0000_0001, 1);
    do_arith(1, 32'h0000_0000, 32'h4000_0000, 0);
    do_arith(1, 32'h3FFF_FFFF, 32'h4000_0000, 0);

    for (int k = 0; k < 60; k++) begin
      r1 = $urandom(); r2 = $urandom();
      if (k % 7 == 3) do_sel(r1, r2);
      else do_arith(k[0], {1'b0, r1[30:0]}, {1'b0, r2[30:0]}, int'($urandom_range(0, 4)));
    end

    do_reject(2'b00, 32'h8000_0001, 32'h0000_0002);
    do_reject(2'b01, 32'h0000_0001, 32'h8000_0002);
    do_sel(32'h8123_4567, 32'h0765_4321);
    do_arith(0, 32'h0000_0005, 32'h0000_0007, 0);
    summary();
  end
endmodule